// File: doc/BRIEF.md
# Closed-Loop PWM Trim Controller

This block holds four converter output voltages on target by closed-loop trim. Each channel receives a filtered 12-bit measurement of its converter's output with a one-cycle valid strobe. On every valid sample, the block compares the full measurement against the channel's target. If the error lies outside a small deadband, it moves that channel's 10-bit trim duty cycle by one step toward the target. The duty drives a PWM pin. An external RC network turns the PWM into a trim voltage for the converter.

The target is normally the nominal set point. When the manufacturing-mode pin is high, the margin-up pin selects the margin-high value and the margin-down pin selects the margin-low value. A per-channel polarity bit tells the block whether a larger duty raises or lowers the converter output. While the run enable is low, every channel is held at its configured default duty. The trim voltage is therefore settled before the rails come up. A shared 10-bit period counter is advanced by a programmable prescaler. A new duty reaches a PWM pin only at the start of a period.

Top module: `trim_ctrl`

## Requirements
- R1: After reset, the commanded duty and the applied duty of every channel are 0, and every PWM pin is low.
- R2: While `run_i` is low, each channel's commanded duty and applied duty are loaded with `dflt_duty_i` on the next clock edge. Measurement strobes have no effect.
- R3: While `run_i` is high, each valid sample changes the channel's commanded duty by exactly one step toward the target. Without a valid sample, the commanded duty does not change.
- R4: When the signed difference between measurement and target is within ±DEADBAND (default 2 LSB, inclusive), the duty does not change. This holds for any target, including margin targets.
- R5: The commanded duty saturates. It never goes above 1023 and never goes below 0.
- R6: With `invert_i[n]`=0, a measurement below target increments the duty and a measurement above target decrements it. With `invert_i[n]`=1, both directions are reversed.
- R7: The target is `mhi_i[n]` when `mfg_mode_i` and `margin_up_i` are high and `margin_dn_i` is low. The target is `mlo_i[n]` when `mfg_mode_i` and `margin_dn_i` are high and `margin_up_i` is low. With `mfg_mode_i` low, the margin pins are ignored and the target is `setpt_i[n]`.
- R8: When both margin pins are high, the target is `setpt_i[n]`.
- R9: Sample strobe n updates only channel n; the other channels keep their duty.
- R10: The period counter advances once every `presc_i`+1 clock cycles and wraps after 1024 counts. PWM pin n is high for `duty_o[n]` counts of each period, so it is always low when the duty is 0.
- R11: With `run_i` high, the applied duty `duty_o[n]` takes the commanded duty only on the clock where the period counter wraps from 1023 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High: closed loop active; low: hold default duty |
| mfg_mode_i | input | 1 | Manufacturing mode, gates the margin pins |
| margin_up_i | input | 1 | Request margin-high target |
| margin_dn_i | input | 1 | Request margin-low target |
| presc_i | input | 8 | Prescaler; counter advances every presc_i+1 cycles |
| meas_i | input | 4x12 | Filtered measurement per channel |
| meas_vld_i | input | 4 | Per-channel sample strobe |
| setpt_i | input | 4x12 | Nominal target per channel |
| mhi_i | input | 4x12 | Margin-high target per channel |
| mlo_i | input | 4x12 | Margin-low target per channel |
| dflt_duty_i | input | 4x10 | Default duty per channel |
| invert_i | input | 4 | Per-channel trim polarity |
| duty_cmd_o | output | 4x10 | Commanded duty from the loop |
| duty_o | output | 4x10 | Duty applied to the PWM |
| pwm_o | output | 4 | PWM outputs |

## Verification
The commanded duty is registered once. A strobe or a run-enable change that is driven before an edge is therefore visible on `duty_cmd_o` after that single edge, and the bench samples it at the following falling edge. The applied duty follows the commanded duty at the next period wrap, which comes up to 1024·(presc_i+1) cycles later. The bench finds the wrap from a channel whose duty is 1023: that pin is low only in count 1023. It then checks `duty_o` both well before and just after the next wrap. PWM high time is measured by counting high samples over exactly one full period while the duty is held.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int MEAS_W = 12;
  localparam int DUTY_W = 10;
  typedef logic [MEAS_W-1:0] meas_t;
  typedef logic [DUTY_W-1:0] duty_t;
endpackage

// File: rtl/trim_tgt.sv
module trim_tgt
  import trim_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              mfg_mode_i,
  input  logic              margin_up_i,
  input  logic              margin_dn_i,
  input  meas_t [NCH-1:0]   setpt_i,
  input  meas_t [NCH-1:0]   mhi_i,
  input  meas_t [NCH-1:0]   mlo_i,
  output meas_t [NCH-1:0]   tgt_o
);
  logic sel_hi, sel_lo;

  // conflicting requests fall back to nominal
  assign sel_hi = mfg_mode_i & margin_up_i & ~margin_dn_i;
  assign sel_lo = mfg_mode_i & margin_dn_i & ~margin_up_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_comb begin
      if (sel_hi)      tgt_o[g] = mhi_i[g];
      else if (sel_lo) tgt_o[g] = mlo_i[g];
      else             tgt_o[g] = setpt_i[g];
    end
  end
endmodule

// File: rtl/trim_step.sv
module trim_step
  import trim_pkg::*;
#(
  parameter int DEADBAND = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  logic  vld_i,
  input  logic  inv_i,
  input  meas_t meas_i,
  input  meas_t tgt_i,
  input  duty_t dflt_i,
  output duty_t cmd_o
);
  localparam int ERR_W = MEAS_W + 1;
  localparam logic signed [ERR_W-1:0] DB_P = ERR_W'(DEADBAND);
  localparam logic signed [ERR_W-1:0] DB_N = -DB_P;
  localparam duty_t DUTY_MAX = '1;

  logic signed [ERR_W-1:0] err;
  logic  above, below, inc, dec;
  duty_t cmd_q;

  assign err   = signed'({1'b0, meas_i}) - signed'({1'b0, tgt_i});
  assign above = err > DB_P;
  assign below = err < DB_N;
  assign inc   = (below & ~inv_i) | (above & inv_i);
  assign dec   = (above & ~inv_i) | (below & inv_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (!run_i) begin
      cmd_q <= dflt_i;
    end else if (vld_i) begin
      if (inc && cmd_q != DUTY_MAX)  cmd_q <= cmd_q + 1'b1;
      else if (dec && cmd_q != '0)   cmd_q <= cmd_q - 1'b1;
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/trim_pwm.sv
module trim_pwm
  import trim_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int PRESC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  duty_t [NCH-1:0]    dflt_i,
  input  duty_t [NCH-1:0]    cmd_i,
  output duty_t [NCH-1:0]    duty_o,
  output logic  [NCH-1:0]    pwm_o,
  output logic               wrap_o
);
  localparam duty_t CNT_LAST = '1;

  logic [PRESC_W-1:0] pre_q;
  duty_t              cnt_q;
  logic               tick;

  assign tick   = (pre_q == presc_i);
  assign wrap_o = tick && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    duty_t act_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      act_q <= '0;
      else if (!run_i)  act_q <= dflt_i[g];
      else if (wrap_o)  act_q <= cmd_i[g];
    end
    assign duty_o[g] = act_q;
    assign pwm_o[g]  = cnt_q < act_q;
  end
endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl
  import trim_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int PRESC_W  = 8,
  parameter int DEADBAND = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               mfg_mode_i,
  input  logic               margin_up_i,
  input  logic               margin_dn_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  meas_t [NCH-1:0]    meas_i,
  input  logic  [NCH-1:0]    meas_vld_i,
  input  meas_t [NCH-1:0]    setpt_i,
  input  meas_t [NCH-1:0]    mhi_i,
  input  meas_t [NCH-1:0]    mlo_i,
  input  duty_t [NCH-1:0]    dflt_duty_i,
  input  logic  [NCH-1:0]    invert_i,
  output duty_t [NCH-1:0]    duty_cmd_o,
  output duty_t [NCH-1:0]    duty_o,
  output logic  [NCH-1:0]    pwm_o
);
  meas_t [NCH-1:0] tgt;
  logic            period_wrap;

  trim_tgt #(.NCH(NCH)) i_tgt (
    .mfg_mode_i  (mfg_mode_i),
    .margin_up_i (margin_up_i),
    .margin_dn_i (margin_dn_i),
    .setpt_i     (setpt_i),
    .mhi_i       (mhi_i),
    .mlo_i       (mlo_i),
    .tgt_o       (tgt)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_step
    trim_step #(.DEADBAND(DEADBAND)) i_step (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_i),
      .vld_i  (meas_vld_i[g]),
      .inv_i  (invert_i[g]),
      .meas_i (meas_i[g]),
      .tgt_i  (tgt[g]),
      .dflt_i (dflt_duty_i[g]),
      .cmd_o  (duty_cmd_o[g])
    );
  end

  trim_pwm #(.NCH(NCH), .PRESC_W(PRESC_W)) i_pwm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .presc_i(presc_i),
    .dflt_i (dflt_duty_i),
    .cmd_i  (duty_cmd_o),
    .duty_o (duty_o),
    .pwm_o  (pwm_o),
    .wrap_o (period_wrap)
  );
endmodule

// File: rtl/trim_ctrl_chk.sv
module trim_ctrl_chk
  import trim_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            run_i,
  input logic [NCH-1:0]  meas_vld_i,
  input duty_t [NCH-1:0] dflt_duty_i,
  input duty_t [NCH-1:0] duty_cmd_o,
  input duty_t [NCH-1:0] duty_o,
  input logic [NCH-1:0]  pwm_o,
  input logic            wrap
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_step_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $past(run_i)) |->
        ({1'b0, duty_cmd_o[g]} == {1'b0, $past(duty_cmd_o[g])} ||
         {1'b0, duty_cmd_o[g]} == {1'b0, $past(duty_cmd_o[g])} + 11'd1 ||
         {1'b0, duty_cmd_o[g]} + 11'd1 == {1'b0, $past(duty_cmd_o[g])}))
      else $error("step larger than one");

    p_hold_no_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $past(run_i) && !$past(meas_vld_i[g])) |-> $stable(duty_cmd_o[g]))
      else $error("duty moved without sample");

    p_preload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && !$past(run_i)) |->
        (duty_cmd_o[g] == $past(dflt_duty_i[g]) && duty_o[g] == $past(dflt_duty_i[g])))
      else $error("default not loaded");

    p_apply_at_wrap_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && $past(run_i) && !$past(wrap)) |-> $stable(duty_o[g]))
      else $error("applied duty changed mid-period");

    p_zero_duty_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (duty_o[g] == '0) |-> !pwm_o[g])
      else $error("pwm high at zero duty");
  end
endmodule

bind trim_ctrl trim_ctrl_chk #(.NCH(NCH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .meas_vld_i  (meas_vld_i),
  .dflt_duty_i (dflt_duty_i),
  .duty_cmd_o  (duty_cmd_o),
  .duty_o      (duty_o),
  .pwm_o       (pwm_o),
  .wrap        (period_wrap)
);

// File: tb/test_trim_ctrl.sv
module test_trim_ctrl;
  import trim_pkg::*;
  localparam int NCH = 4;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst_ni = 0, run = 0, mfg = 0, mup = 0, mdn = 0;
  logic [7:0] presc = 0;
  meas_t [NCH-1:0] meas, setpt, mhi, mlo;
  logic  [NCH-1:0] vld = 0, inv = 0;
  duty_t [NCH-1:0] dflt, cmd, duty;
  logic  [NCH-1:0] pwm;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trim_ctrl i_trim_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run), .mfg_mode_i(mfg),
    .margin_up_i(mup), .margin_dn_i(mdn), .presc_i(presc),
    .meas_i(meas), .meas_vld_i(vld), .setpt_i(setpt), .mhi_i(mhi), .mlo_i(mlo),
    .dflt_duty_i(dflt), .invert_i(inv), .duty_cmd_o(cmd), .duty_o(duty), .pwm_o(pwm)
  );

  typedef struct packed {
    logic mfg, up, dn, inv;
    logic [11:0] meas;
    logic [9:0]  dflt;
    logic [9:0]  exp;
  } vec_t;

  // setpt 2000, margin high 2100, margin low 1900, deadband 2
  localparam vec_t VECS [16] = '{
    '{1'b0,1'b0,1'b0,1'b0,12'd1990,10'd500,10'd501},  // R3 R6 below -> up
    '{1'b0,1'b0,1'b0,1'b0,12'd2010,10'd500,10'd499},  // R3 R6 above -> down
    '{1'b0,1'b0,1'b0,1'b1,12'd1990,10'd500,10'd499},  // R6 inverted
    '{1'b0,1'b0,1'b0,1'b1,12'd2010,10'd500,10'd501},  // R6 inverted
    '{1'b0,1'b0,1'b0,1'b0,12'd2002,10'd500,10'd500},  // R4 +2 edge
    '{1'b0,1'b0,1'b0,1'b0,12'd1998,10'd500,10'd500},  // R4 -2 edge
    '{1'b0,1'b0,1'b0,1'b0,12'd2003,10'd500,10'd499},  // R4 +3 outside
    '{1'b0,1'b0,1'b0,1'b0,12'd1997,10'd500,10'd501},  // R4 -3 outside
    '{1'b1,1'b1,1'b0,1'b0,12'd2050,10'd500,10'd501},  // R7 margin high target
    '{1'b0,1'b1,1'b0,1'b0,12'd2050,10'd500,10'd499},  // R7 gated off
    '{1'b1,1'b0,1'b1,1'b0,12'd2000,10'd500,10'd499},  // R7 margin low target
    '{1'b1,1'b0,1'b1,1'b0,12'd1898,10'd500,10'd500},  // R4 R7 deadband on margin
    '{1'b1,1'b1,1'b1,1'b0,12'd2050,10'd500,10'd499},  // R8 both -> nominal
    '{1'b1,1'b1,1'b1,1'b0,12'd1950,10'd500,10'd501},  // R8 both -> nominal
    '{1'b0,1'b0,1'b0,1'b0,12'd1000,10'd1023,10'd1023}, // R5 top
    '{1'b0,1'b0,1'b0,1'b0,12'd3000,10'd0,10'd0}        // R5 bottom
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_all(input meas_t m, input duty_t d, input logic iv);
    for (int c = 0; c < NCH; c++) begin meas[c] = m; dflt[c] = d; end
    inv = {NCH{iv}};
  endtask

  task automatic preload;
    @(negedge clk); run = 0;
    @(negedge clk); run = 1;
  endtask

  task automatic pulse(input logic [NCH-1:0] m);
    vld = m;
    @(negedge clk); vld = '0;
  endtask

  task automatic count_high(input int ch, input int cycles, output int hi);
    hi = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk); if (pwm[ch]) hi++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int hi;
    for (int c = 0; c < NCH; c++) begin
      setpt[c] = 12'd2000; mhi[c] = 12'd2100; mlo[c] = 12'd1900;
    end
    set_all(12'd2000, 10'd500, 1'b0);

    // R1 reset state
    #(CLK_PERIOD * 3);
    chk(cmd == '0 && duty == '0 && pwm == '0, "R1", int'(duty[0]), 0);
    @(negedge clk); rst_ni = 1;
    @(negedge clk);

    // table walk
    foreach (VECS[i]) begin
      set_all(VECS[i].meas, VECS[i].dflt, VECS[i].inv);
      mfg = VECS[i].mfg; mup = VECS[i].up; mdn = VECS[i].dn;
      preload();
      pulse('1);
      for (int c = 0; c < NCH; c++)
        chk(cmd[c] == VECS[i].exp, $sformatf("vec%0d ch%0d R3-R8", i, c),
            int'(cmd[c]), int'(VECS[i].exp));
    end
    mfg = 0; mup = 0; mdn = 0;

    // R2: strobes ignored while run low; default loaded
    set_all(12'd100, 10'd321, 1'b0);
    @(negedge clk); run = 0; vld = '1;
    @(negedge clk); @(negedge clk); vld = '0;
    chk(cmd[1] == 10'd321 && duty[1] == 10'd321, "R2", int'(cmd[1]), 321);

    // R3: several samples, then idle
    preload();
    for (int k = 0; k < 5; k++) pulse('1);
    chk(cmd[0] == 10'd326, "R3 five samples", int'(cmd[0]), 326);
    repeat (4) @(negedge clk);
    chk(cmd[0] == 10'd326, "R3 no sample hold", int'(cmd[0]), 326);

    // R9: only channel 2 strobed
    preload();
    pulse(4'b0100);
    chk(cmd[2] == 10'd322, "R9 ch2 moved", int'(cmd[2]), 322);
    chk(cmd[0] == 10'd321 && cmd[1] == 10'd321 && cmd[3] == 10'd321,
        "R9 others held", int'(cmd[3]), 321);

    // R10: high time over a full period
    dflt[0] = 10'd256; dflt[1] = 10'd0; dflt[2] = 10'd700; dflt[3] = 10'd1023;
    meas = {NCH{12'd2000}};
    presc = 0;
    @(negedge clk); run = 0;
    count_high(0, 1024, hi);
    chk(hi == 256, "R10 duty 256", hi, 256);
    count_high(1, 1024, hi);
    chk(hi == 0, "R10 duty 0", hi, 0);
    count_high(3, 1024, hi);
    chk(hi == 1023, "R10 duty 1023", hi, 1023);
    presc = 8'd1;
    count_high(2, 2048, hi);
    chk(hi == 1400, "R10 prescale 2", hi, 1400);

    // R11: applied duty changes only at the period wrap
    presc = 0;
    dflt[0] = 10'd100;
    @(negedge clk);
    @(negedge clk); run = 1;
    meas[0] = 12'd1000;
    // ch3 at 1023 is low only in count 1023
    while (pwm[3]) @(negedge clk);
    @(negedge clk);
    pulse(4'b0001);
    chk(cmd[0] == 10'd101, "R11 command", int'(cmd[0]), 101);
    repeat (1000) @(negedge clk);
    chk(duty[0] == 10'd100, "R11 held mid-period", int'(duty[0]), 100);
    repeat (30) @(negedge clk);
    chk(duty[0] == 10'd101, "R11 applied after wrap", int'(duty[0]), 101);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule